// File: doc/BRIEF.md
# Fragmented Message Sequence Checker

This block follows the reassembly of fragmented CAN messages for a set of receive message objects. For every accepted frame it gets a descriptor: the object number, the protocol mode, a start-of-message flag and the fragment count. From these it decides whether the frame continues its object's message in order. The mode sets how wide the fragment count is: six bits, four bits, or a single bit that must toggle. A start-of-message frame always resets that object's buffer pointer, and restarting a message that is already in progress is accepted silently.

Two kinds of message error share one sticky error flag and one info register. The first is a fragment count that arrives out of order. The second is a transmit underflow, reported by the transmit engine when it runs out of data because the DMA could not get the bus. The info register holds the object number of the latest error and a type bit that says which kind it was. Software clears the flag with a write-1 pulse.

Top module: `frag_seq_chk`

## Requirements
- R1: After reset, `ptr_rst_o`, `msg_err_o` and `err_info_o` are all zero and every object is idle.
- R2: In mode 2'b00 the fragment count is 6 bits wide. A continuation frame must carry the previous count plus one modulo 64, so 63 is followed by 0.
- R3: In mode 2'b01 only `frm_cnt_i[3:0]` is compared. The higher count bits are ignored, and the count advances modulo 16, so 15 is followed by 0.
- R4: In modes 2'b10 and 2'b11 only `frm_cnt_i[0]` is compared, and it must toggle on every continuation frame.
- R5: A valid start-of-message frame pulses `ptr_rst_o[obj]` for exactly one cycle, starting the cycle after the frame. The frame's masked count becomes the reference for the next frame. It never raises an error, even when it arrives while that object's message is still in progress.
- R6: A continuation frame for an idle object is a fragmentation error. Any fragmentation error returns its object to idle.
- R7: On an error, `msg_err_o` is 1 from the next cycle onward. `err_info_o[5]` gives the type (0 = fragmentation, 1 = transmit underflow) and `err_info_o[4:0]` gives the object number. Cycles with no error leave `err_info_o` unchanged.
- R8: A pulse on `err_clr_i` clears `msg_err_o` on the next cycle and leaves `err_info_o` alone. If a new error occurs in the same cycle as the clear, the flag stays set.
- R9: If a fragmentation error and a transmit underflow occur in the same cycle, `err_info_o` records the fragmentation error.
- R10: Each object keeps its own progress state and reference count, so frames for one object never change how frames for another object are judged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frm_valid_i | input | 1 | Frame descriptor strobe |
| frm_obj_i | input | 5 | Object number of the frame |
| frm_mode_i | input | 2 | Protocol mode of the frame |
| frm_som_i | input | 1 | Start-of-message flag |
| frm_cnt_i | input | 6 | Fragment count of the frame |
| txu_valid_i | input | 1 | Transmit underflow event |
| txu_obj_i | input | 5 | Object number that underflowed |
| err_clr_i | input | 1 | Write-1 clear of the error flag |
| ptr_rst_o | output | 32 | Per-object buffer pointer reset pulse |
| msg_err_o | output | 1 | Sticky message error flag |
| err_info_o | output | 6 | {type, object} of the latest error |

## Verification
The hardest case to reach is the 6-bit wrap from 63 to 0. Random counts almost never survive 64 in-order frames on one object. The bench therefore drives a directed run of 64 consecutive correct frames to a single object, and follows it with a frame carrying count 0 and a frame carrying count 1. The 4-bit wrap gets a similar directed run, in which the upper count bits are set while the low nibble is correct. A long random run keeps a few objects in flight at once and mostly feeds correct counts, so messages stay alive for many frames before they are broken by restarts, wrong counts, underflows and clears.

// File: rtl/frag_seq_pkg.sv
package frag_seq_pkg;

  localparam int unsigned CNT_W = 6;

  typedef enum logic [1:0] {
    MODE_W6  = 2'b00,
    MODE_W4  = 2'b01,
    MODE_T1  = 2'b10,
    MODE_T1X = 2'b11
  } frag_mode_e;

  function automatic logic [CNT_W-1:0] cnt_mask(input logic [1:0] mode);
    logic [CNT_W-1:0] m;
    unique case (frag_mode_e'(mode))
      MODE_W6: m = 6'h3f;
      MODE_W4: m = 6'h0f;
      default: m = 6'h01;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/frag_seq_state.sv
module frag_seq_state
  import frag_seq_pkg::*;
#(
  parameter int unsigned NOBJ  = 32,
  parameter int unsigned OBJ_W = $clog2(NOBJ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frm_valid_i,
  input  logic [OBJ_W-1:0] frm_obj_i,
  input  logic [1:0]       frm_mode_i,
  input  logic             frm_som_i,
  input  logic [CNT_W-1:0] frm_cnt_i,
  output logic             frag_err_o,
  output logic [NOBJ-1:0]  ptr_rst_o
);

  logic [NOBJ-1:0]  inprog;
  logic [CNT_W-1:0] last [NOBJ];
  logic [CNT_W-1:0] mask, cnt_m, want;
  logic             in_seq;

  always_comb begin
    mask   = cnt_mask(frm_mode_i);
    cnt_m  = frm_cnt_i & mask;
    want   = (last[frm_obj_i] + CNT_W'(1)) & mask;
    in_seq = inprog[frm_obj_i] && (cnt_m == want);
  end

  assign frag_err_o = frm_valid_i && !frm_som_i && !in_seq;

  for (genvar g = 0; g < NOBJ; g++) begin : g_obj
    logic             sel;
    logic             inprog_r;
    logic [CNT_W-1:0] last_r;
    logic             ptr_r;

    assign sel = frm_valid_i && (frm_obj_i == OBJ_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        inprog_r <= 1'b0;
        last_r   <= '0;
        ptr_r    <= 1'b0;
      end else begin
        ptr_r <= sel && frm_som_i;
        if (sel) begin
          if (frm_som_i || in_seq) begin
            inprog_r <= 1'b1;
            last_r   <= cnt_m;
          end else begin
            inprog_r <= 1'b0;  // broken message is dropped
          end
        end
      end
    end

    assign inprog[g]    = inprog_r;
    assign last[g]      = last_r;
    assign ptr_rst_o[g] = ptr_r;
  end

  // R5
  ptr_rst_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ptr_rst_o));

  // R5
  ptr_rst_on_som_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_valid_i && frm_som_i && (32'(frm_obj_i) < NOBJ)) |=> ptr_rst_o[$past(frm_obj_i)]);

endmodule

// File: rtl/frag_seq_err.sv
module frag_seq_err #(
  parameter int unsigned OBJ_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frag_err_i,
  input  logic [OBJ_W-1:0] frag_obj_i,
  input  logic             txu_i,
  input  logic [OBJ_W-1:0] txu_obj_i,
  input  logic             clr_i,
  output logic             flag_o,
  output logic [OBJ_W:0]   info_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      info_o <= '0;
    end else begin
      if (frag_err_i || txu_i) flag_o <= 1'b1;  // set beats clear
      else if (clr_i)          flag_o <= 1'b0;
      if (frag_err_i)          info_o <= {1'b0, frag_obj_i};
      else if (txu_i)          info_o <= {1'b1, txu_obj_i};
    end
  end

  // R7
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frag_err_i || txu_i) |=> flag_o);

  // R8
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !frag_err_i && !txu_i) |=> !flag_o);

  // R7
  info_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frag_err_i && !txu_i) |=> $stable(info_o));

  // R9
  info_frag_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frag_err_i && txu_i) |=> !info_o[OBJ_W]);

endmodule

// File: rtl/frag_seq_chk.sv
module frag_seq_chk
  import frag_seq_pkg::*;
#(
  parameter  int unsigned NOBJ  = 32,
  localparam int unsigned OBJ_W = $clog2(NOBJ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frm_valid_i,
  input  logic [OBJ_W-1:0] frm_obj_i,
  input  logic [1:0]       frm_mode_i,
  input  logic             frm_som_i,
  input  logic [CNT_W-1:0] frm_cnt_i,
  input  logic             txu_valid_i,
  input  logic [OBJ_W-1:0] txu_obj_i,
  input  logic             err_clr_i,
  output logic [NOBJ-1:0]  ptr_rst_o,
  output logic             msg_err_o,
  output logic [OBJ_W:0]   err_info_o
);

  logic frag_err;

  frag_seq_state #(.NOBJ(NOBJ), .OBJ_W(OBJ_W)) u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frm_valid_i (frm_valid_i),
    .frm_obj_i   (frm_obj_i),
    .frm_mode_i  (frm_mode_i),
    .frm_som_i   (frm_som_i),
    .frm_cnt_i   (frm_cnt_i),
    .frag_err_o  (frag_err),
    .ptr_rst_o   (ptr_rst_o)
  );

  frag_seq_err #(.OBJ_W(OBJ_W)) u_err (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frag_err_i (frag_err),
    .frag_obj_i (frm_obj_i),
    .txu_i      (txu_valid_i),
    .txu_obj_i  (txu_obj_i),
    .clr_i      (err_clr_i),
    .flag_o     (msg_err_o),
    .info_o     (err_info_o)
  );

  // R6
  idle_cont_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_valid_i && frm_som_i) |=> !(frm_valid_i && !frm_som_i && (frm_obj_i == $past(frm_obj_i))
                                      && !frag_err && (frm_cnt_i[0] == $past(frm_cnt_i[0]))
                                      && ($past(frm_mode_i) == frm_mode_i)));

endmodule

// File: tb/frag_seq_chk_bench.sv
module frag_seq_chk_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_valid = 1'b0;
  logic [4:0]  frm_obj = '0;
  logic [1:0]  frm_mode = '0;
  logic        frm_som = 1'b0;
  logic [5:0]  frm_cnt = '0;
  logic        txu_valid = 1'b0;
  logic [4:0]  txu_obj = '0;
  logic        err_clr = 1'b0;
  logic [31:0] ptr_rst;
  logic        msg_err;
  logic [5:0]  err_info;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  logic [5:0]  m_last [32];
  logic        m_inprog [32];
  logic        m_flag;
  logic [5:0]  m_info;

  always #2.5 clk = ~clk;

  frag_seq_chk u_frag_seq_chk (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .frm_valid_i (frm_valid),
    .frm_obj_i   (frm_obj),
    .frm_mode_i  (frm_mode),
    .frm_som_i   (frm_som),
    .frm_cnt_i   (frm_cnt),
    .txu_valid_i (txu_valid),
    .txu_obj_i   (txu_obj),
    .err_clr_i   (err_clr),
    .ptr_rst_o   (ptr_rst),
    .msg_err_o   (msg_err),
    .err_info_o  (err_info)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  function automatic logic [5:0] mask_of(input logic [1:0] m);
    return (m == 2'b00) ? 6'h3f : (m == 2'b01) ? 6'h0f : 6'h01;
  endfunction

  function automatic logic [5:0] next_cnt(input logic [4:0] o, input logic [1:0] m);
    return (m_last[o] + 6'd1) & mask_of(m);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [4:0] o, input logic [1:0] m, input logic s,
                      input logic [5:0] c, input logic tv, input logic [4:0] to, input logic cl,
                      input string tag);
    logic        frag;
    logic [31:0] e_ptr;
    @(negedge clk);
    frm_valid = v; frm_obj = o; frm_mode = m; frm_som = s; frm_cnt = c;
    txu_valid = tv; txu_obj = to; err_clr = cl;
    frag  = v && !s && (!m_inprog[o] || ((c & mask_of(m)) != next_cnt(o, m)));
    e_ptr = (v && s) ? (32'd1 << o) : 32'd0;
    if (v) begin
      if (s || !frag) begin m_inprog[o] = 1'b1; m_last[o] = c & mask_of(m); end
      else m_inprog[o] = 1'b0;
    end
    if (frag || tv) m_flag = 1'b1;
    else if (cl)    m_flag = 1'b0;
    if (frag)       m_info = {1'b0, o};
    else if (tv)    m_info = {1'b1, to};
    @(posedge clk);
    #1;
    chk(ptr_rst, e_ptr, tag, "ptr_rst_o");
    chk({31'd0, msg_err}, {31'd0, m_flag}, tag, "msg_err_o");
    chk({26'd0, err_info}, {26'd0, m_info}, tag, "err_info_o");
  endtask

  task automatic frm(input logic [4:0] o, input logic [1:0] m, input logic s, input logic [5:0] c, input string tag);
    step(1'b1, o, m, s, c, 1'b0, 5'd0, 1'b0, tag);
  endtask

  task automatic clear(input string tag);
    step(1'b0, 5'd0, 2'b00, 1'b0, 6'd0, 1'b0, 5'd0, 1'b1, tag);
  endtask

  initial begin
    logic [4:0] picks [5];
    picks[0] = 5'd0; picks[1] = 5'd1; picks[2] = 5'd2; picks[3] = 5'd3; picks[4] = 5'd31;
    for (int i = 0; i < 32; i++) begin m_last[i] = '0; m_inprog[i] = 1'b0; end
    m_flag = 1'b0; m_info = '0;
    void'($urandom(32'h5eed_c0de));

    // R1 reset state
    #12;
    chk(ptr_rst, 32'd0, "R1", "ptr_rst_o");
    chk({31'd0, msg_err}, 32'd0, "R1", "msg_err_o");
    chk({26'd0, err_info}, 32'd0, "R1", "err_info_o");
    @(negedge clk); rst_n = 1'b1;

    // R4 toggle bit, mode 10 and 11
    frm(5'd2, 2'b10, 1'b1, 6'd0, "R4");
    frm(5'd2, 2'b10, 1'b0, 6'd1, "R4");
    frm(5'd2, 2'b11, 1'b0, 6'h3e, "R4");
    frm(5'd2, 2'b10, 1'b0, 6'd1, "R4");
    frm(5'd2, 2'b10, 1'b0, 6'd1, "R4");
    clear("R8");

    // R3 4-bit wrap, upper bits ignored
    frm(5'd5, 2'b01, 1'b1, 6'd14, "R3");
    frm(5'd5, 2'b01, 1'b0, 6'd15, "R3");
    frm(5'd5, 2'b01, 1'b0, 6'h30, "R3");
    frm(5'd5, 2'b01, 1'b0, 6'h21, "R3");
    frm(5'd5, 2'b01, 1'b0, 6'd3, "R3");
    clear("R8");

    // R2 6-bit wrap 63 -> 0
    frm(5'd7, 2'b00, 1'b1, 6'd0, "R2");
    for (int k = 1; k < 64; k++) frm(5'd7, 2'b00, 1'b0, 6'(k), "R2");
    frm(5'd7, 2'b00, 1'b0, 6'd0, "R2");
    frm(5'd7, 2'b00, 1'b0, 6'd1, "R2");
    frm(5'd7, 2'b00, 1'b0, 6'd1, "R2");
    clear("R8");

    // R5 restart mid-message, no error
    frm(5'd9, 2'b00, 1'b1, 6'd3, "R5");
    frm(5'd9, 2'b00, 1'b0, 6'd4, "R5");
    frm(5'd9, 2'b00, 1'b1, 6'd20, "R5");
    frm(5'd9, 2'b00, 1'b0, 6'd21, "R5");

    // R6 idle continuation, and object idle after an error
    frm(5'd11, 2'b00, 1'b0, 6'd0, "R6");
    frm(5'd9, 2'b00, 1'b0, 6'd30, "R6");
    clear("R8");
    frm(5'd9, 2'b00, 1'b0, 6'd22, "R6");

    // R7 underflow info
    step(1'b0, 5'd0, 2'b00, 1'b0, 6'd0, 1'b1, 5'd30, 1'b0, "R7");
    // R8 clear leaves info, set beats clear
    clear("R8");
    step(1'b0, 5'd0, 2'b00, 1'b0, 6'd0, 1'b1, 5'd17, 1'b1, "R8");
    step(1'b1, 5'd11, 2'b00, 1'b0, 6'd5, 1'b0, 5'd0, 1'b1, "R8");
    clear("R8");
    // R9 fragmentation wins the info register
    step(1'b1, 5'd11, 2'b00, 1'b0, 6'd5, 1'b1, 5'd4, 1'b0, "R9");

    // R10 random interleaving across objects
    for (int n = 0; n < 4000; n++) begin
      logic [4:0] o;
      logic [1:0] m;
      logic       s;
      logic [5:0] c;
      o = picks[$urandom_range(0, 4)];
      m = ($urandom_range(0, 15) == 0) ? 2'($urandom) : 2'(o % 4);
      s = ($urandom_range(0, 7) == 0) || !m_inprog[o] && ($urandom_range(0, 1) == 0);
      c = ($urandom_range(0, 7) != 0) ? (next_cnt(o, m) | (6'($urandom) & ~mask_of(m))) : 6'($urandom);
      step($urandom_range(0, 3) != 0, o, m, s, c,
           $urandom_range(0, 31) == 0, 5'($urandom), $urandom_range(0, 7) == 0, "R10");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule